// File: doc/BRIEF.md
# Serial-port buffer transfer engine

This block moves characters between a serial port and memory without processor involvement. It holds two independent channels. The receive channel copies each character the port has received into memory. The transmit channel fetches each character to be sent from memory. Each channel keeps a buffer address and a remaining-transfer count. Software loads both values through a small write port. The block issues one memory request per character on a single request/acknowledge port. When a channel's count runs out, its end-of-buffer flag rises for the interrupt logic, and the channel stops.

A channel starts working when software writes a non-zero count. A transfer starts when the port raises its ready flag. Each acknowledged request advances the pointer by one byte address and lowers the count by one. The channel then reports the character as consumed to the port. When both channels want the memory port in the same idle cycle, receive wins. While the port runs with 9-bit characters, neither channel starts a transfer.

Each channel is a three-state machine: `CH_OFF` (count zero or stopped), `CH_WAIT` (armed, waiting for ready and a grant) and `CH_BUSY` (request outstanding). Its transitions are named *arm* (OFF to WAIT, on a non-zero count write), *disarm* (WAIT to OFF, on a zero count write), *launch* (WAIT to BUSY, on grant), *rearm* (BUSY to WAIT, on an acknowledge that leaves a count) and *finish* (BUSY to OFF, on the acknowledge of the last transfer). The shared port arbiter has the states `ARB_IDLE`, `ARB_RX` and `ARB_TX`. Its transitions are *take_rx* and *take_tx* (out of IDLE) and *release* (back to IDLE on acknowledge).

Top module: `chan_xfer_dma`

## Requirements
- R1: During and immediately after reset, mem_req, rx_take, tx_take, end_rx and end_tx are all low.
- R2: A configuration write with cfg_sel = 0 loads the receive pointer, 1 the receive count, 2 the transmit pointer and 3 the transmit count. The count takes the low CNT_W bits of cfg_wdata.
- R3: With a non-zero receive count and rx_ready high, the block issues a write request with mem_we = 1, mem_addr equal to the receive pointer and mem_wdata equal to rx_data. rx_take is high for exactly the acknowledge cycle.
- R4: With a non-zero transmit count and tx_ready high, the block issues a read request with mem_we = 0. In the acknowledge cycle tx_take is high and tx_data carries mem_rdata.
- R5: Each acknowledged transfer advances that channel's pointer by one and lowers its count by one. Successive transfers therefore use consecutive addresses.
- R6: The acknowledge that brings a count to zero sets that channel's end flag in the next cycle. After that, the channel issues no request even with its ready flag held high.
- R7: Writing a non-zero count clears the channel's end flag and resumes transfers from the current pointer. Writing a zero count stops the channel and leaves its end flag unchanged.
- R8: While nine_bit is high, no new memory request starts.
- R9: When both channels are ready in the same idle cycle, the receive channel's request is issued first.
- R10: Only one request is outstanding at a time. mem_req, mem_addr and mem_we hold steady until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nine_bit | input | 1 | Port uses 9-bit characters; blocks new transfers |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 rx pointer, 1 rx count, 2 tx pointer, 3 tx count |
| cfg_wdata | input | ADDR_W | Configuration write value |
| rx_ready | input | 1 | Receiver holds a character |
| rx_data | input | DATA_W | Received character |
| rx_take | output | 1 | Received character consumed |
| tx_ready | input | 1 | Transmitter can accept a character |
| tx_take | output | 1 | tx_data valid; transmitter must accept it |
| tx_data | output | DATA_W | Character for the transmitter |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write (receive), 0 read (transmit) |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request completed |
| end_rx | output | 1 | Receive buffer exhausted |
| end_tx | output | 1 | Transmit buffer exhausted |

## Verification
Two things can fall in the same cycle. First, both channels can become ready while the memory port is idle. Second, a software count write can arrive while a channel is stalled or finished. The bench raises rx_ready and tx_ready on the same clock edge. It checks that the first request seen is a write and that rx_take precedes tx_take. It also writes zero and non-zero counts around a partially used buffer, and judges the result by the addresses of later requests and by the end flag. Sweeps over counts 1 to 4 and memory latencies 0 to 2 cycles cover each direction. The expected addresses and data are computed from the programmed base and an arithmetic byte pattern.

// File: rtl/chan_xfer_pkg.sv
package chan_xfer_pkg;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_WAIT = 2'd1,
        CH_BUSY = 2'd2
    } ch_state_e;

    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_RX   = 2'd1,
        ARB_TX   = 2'd2
    } arb_state_e;

    localparam logic [1:0] SEL_RX_PTR = 2'd0;
    localparam logic [1:0] SEL_RX_CNT = 2'd1;
    localparam logic [1:0] SEL_TX_PTR = 2'd2;
    localparam logic [1:0] SEL_TX_CNT = 2'd3;

endpackage

// File: rtl/chan_xfer_regdec.sv
module chan_xfer_regdec
    import chan_xfer_pkg::*;
(
    input  logic       cfg_we,
    input  logic [1:0] cfg_sel,
    output logic       rx_ptr_we,
    output logic       rx_cnt_we,
    output logic       tx_ptr_we,
    output logic       tx_cnt_we
);

    always_comb begin
        rx_ptr_we = cfg_we && (cfg_sel == SEL_RX_PTR);
        rx_cnt_we = cfg_we && (cfg_sel == SEL_RX_CNT);
        tx_ptr_we = cfg_we && (cfg_sel == SEL_TX_PTR);
        tx_cnt_we = cfg_we && (cfg_sel == SEL_TX_CNT);
    end

endmodule

// File: rtl/chan_xfer_channel.sv
module chan_xfer_channel
    import chan_xfer_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_we,
    input  logic              cnt_we,
    input  logic [ADDR_W-1:0] wval,
    input  logic              ready,
    input  logic              enable,
    input  logic              grant,
    input  logic              done,
    output logic              want,
    output logic              busy,
    output logic              end_flag,
    output logic [ADDR_W-1:0] ptr
);

    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0]  CNT_ZERO = '0;
    localparam logic [ADDR_W-1:0] PTR_STEP = ADDR_W'(1);

    ch_state_e         st_q, st_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  new_cnt;
    logic              new_nz;
    logic              last_xfer;

    assign new_cnt   = wval[CNT_W-1:0];
    assign new_nz    = (new_cnt != CNT_ZERO);
    assign last_xfer = (cnt_q <= CNT_ONE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= CH_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // next state: arm, disarm, launch, rearm, finish
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_OFF: begin
                if (cnt_we && new_nz) st_d = CH_WAIT;            // arm
            end
            CH_WAIT: begin
                if (grant)                    st_d = CH_BUSY;    // launch
                else if (cnt_we && !new_nz)   st_d = CH_OFF;     // disarm
            end
            CH_BUSY: begin
                if (done) begin
                    if (cnt_we)         st_d = new_nz ? CH_WAIT : CH_OFF;
                    else if (last_xfer) st_d = CH_OFF;           // finish
                    else                st_d = CH_WAIT;          // rearm
                end
            end
            default: st_d = CH_OFF;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= CNT_ZERO;
            ptr      <= '0;
            end_flag <= 1'b0;
        end else begin
            if (cnt_we)                             cnt_q <= new_cnt;
            else if (done && (cnt_q != CNT_ZERO))   cnt_q <= cnt_q - CNT_ONE;

            if (ptr_we)    ptr <= wval;
            else if (done) ptr <= ptr + PTR_STEP;

            if (cnt_we && new_nz)                        end_flag <= 1'b0;
            else if (done && !cnt_we && (cnt_q == CNT_ONE)) end_flag <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        want = (st_q == CH_WAIT) && ready && enable;
        busy = (st_q == CH_BUSY);
    end

endmodule

// File: rtl/chan_xfer_arbiter.sv
module chan_xfer_arbiter
    import chan_xfer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_want,
    input  logic tx_want,
    input  logic mem_ack,
    output logic rx_grant,
    output logic tx_grant,
    output logic rx_done,
    output logic tx_done,
    output logic sel_rx,
    output logic active
);

    arb_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ARB_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state: take_rx, take_tx, release
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ARB_IDLE: begin
                if (rx_want)      st_d = ARB_RX;   // take_rx (priority)
                else if (tx_want) st_d = ARB_TX;   // take_tx
            end
            ARB_RX:  if (mem_ack) st_d = ARB_IDLE; // release
            ARB_TX:  if (mem_ack) st_d = ARB_IDLE; // release
            default: st_d = ARB_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rx_grant = (st_q == ARB_IDLE) && rx_want;
        tx_grant = (st_q == ARB_IDLE) && !rx_want && tx_want;
        rx_done  = (st_q == ARB_RX) && mem_ack;
        tx_done  = (st_q == ARB_TX) && mem_ack;
        sel_rx   = (st_q == ARB_RX);
        active   = (st_q != ARB_IDLE);
    end

endmodule

// File: rtl/chan_xfer_dma.sv
module chan_xfer_dma
    import chan_xfer_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nine_bit,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              rx_ready,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_take,
    input  logic              tx_ready,
    output logic              tx_take,
    output logic [DATA_W-1:0] tx_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              end_rx,
    output logic              end_tx
);

    logic rx_ptr_we, rx_cnt_we, tx_ptr_we, tx_cnt_we;
    logic rx_want, tx_want, rx_grant, tx_grant, rx_done, tx_done;
    logic rx_busy, tx_busy, sel_rx, active;
    logic [ADDR_W-1:0] rx_ptr, tx_ptr;

    chan_xfer_regdec u_dec (
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .rx_ptr_we (rx_ptr_we),
        .rx_cnt_we (rx_cnt_we),
        .tx_ptr_we (tx_ptr_we),
        .tx_cnt_we (tx_cnt_we)
    );

    chan_xfer_channel #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .ptr_we   (rx_ptr_we),
        .cnt_we   (rx_cnt_we),
        .wval     (cfg_wdata),
        .ready    (rx_ready),
        .enable   (!nine_bit),
        .grant    (rx_grant),
        .done     (rx_done),
        .want     (rx_want),
        .busy     (rx_busy),
        .end_flag (end_rx),
        .ptr      (rx_ptr)
    );

    chan_xfer_channel #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .ptr_we   (tx_ptr_we),
        .cnt_we   (tx_cnt_we),
        .wval     (cfg_wdata),
        .ready    (tx_ready),
        .enable   (!nine_bit),
        .grant    (tx_grant),
        .done     (tx_done),
        .want     (tx_want),
        .busy     (tx_busy),
        .end_flag (end_tx),
        .ptr      (tx_ptr)
    );

    chan_xfer_arbiter u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_want  (rx_want),
        .tx_want  (tx_want),
        .mem_ack  (mem_ack),
        .rx_grant (rx_grant),
        .tx_grant (tx_grant),
        .rx_done  (rx_done),
        .tx_done  (tx_done),
        .sel_rx   (sel_rx),
        .active   (active)
    );

    always_comb begin
        mem_req   = active;
        mem_we    = sel_rx;
        mem_addr  = sel_rx ? rx_ptr : tx_ptr;
        mem_wdata = sel_rx ? rx_data : '0;
        tx_data   = mem_rdata;
        rx_take   = rx_done;
        tx_take   = tx_done;
    end

endmodule

// File: rtl/chan_xfer_dma_chk.sv
module chan_xfer_dma_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              nine_bit,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rx_take,
    input logic              tx_take,
    input logic              end_rx,
    input logic              end_tx,
    input logic              rx_busy,
    input logic              tx_busy
);

    p_one_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_busy && tx_busy));

    p_req_owner_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (rx_busy || tx_busy));

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_no_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (nine_bit && !mem_req) |=> !mem_req);

    p_rx_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_take |-> (mem_req && mem_ack && mem_we));

    p_tx_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |-> (mem_req && mem_ack && !mem_we));

    p_end_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_rx) |-> $past(rx_take));

    p_end_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_tx) |-> $past(tx_take));

endmodule

bind chan_xfer_dma chan_xfer_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .nine_bit (nine_bit),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .rx_take  (rx_take),
    .tx_take  (tx_take),
    .end_rx   (end_rx),
    .end_tx   (end_tx),
    .rx_busy  (rx_busy),
    .tx_busy  (tx_busy)
);

// File: tb/chan_xfer_dma_tb_top.sv
`timescale 1ns/1ps
module chan_xfer_dma_tb_top;

    localparam int AW = 16;
    localparam int CW = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          nine_bit = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          rx_ready = 1'b0;
    logic [DW-1:0] rx_data = '0;
    logic          rx_take;
    logic          tx_ready = 1'b0;
    logic          tx_take;
    logic [DW-1:0] tx_data;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          mem_ack = 1'b0;
    logic          end_rx, end_tx;

    int errors = 0;
    int checks = 0;
    bit done_flag = 1'b0;

    // memory model
    logic [DW-1:0] mem [256];
    int            mem_lat = 0;
    int            wcnt = 0;
    logic          pre_we = 1'b0;
    logic [7:0]    pre_addr = '0;
    logic [DW-1:0] pre_data = '0;

    always #2.5 clk = ~clk;

    chan_xfer_dma #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .nine_bit(nine_bit),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .rx_ready(rx_ready), .rx_data(rx_data), .rx_take(rx_take),
        .tx_ready(tx_ready), .tx_take(tx_take), .tx_data(tx_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .end_rx(end_rx), .end_tx(end_tx)
    );

    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (pre_we) mem[pre_addr] <= pre_data;
        if (!rst_n) begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        end else if (mem_req) begin
            if (wcnt >= mem_lat) begin
                mem_ack <= 1'b1;
                wcnt    <= 0;
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 37 + i * 11 + 3) & 255);
    endfunction

    task automatic cfg_write(input logic [1:0] sel, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = AW'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic preload(input int addr, input logic [7:0] val);
        @(negedge clk);
        pre_we = 1'b1; pre_addr = 8'(addr); pre_data = val;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    // wait for a take pulse on one channel; returns the address seen
    task automatic wait_take(input bit is_rx, output bit seen, output int addr,
                             output int wdat, output int rdat, output bit we);
        seen = 1'b0; addr = 0; wdat = 0; rdat = 0; we = 1'b0;
        for (int k = 0; k < 60 && !seen; k++) begin
            @(negedge clk);
            if ((is_rx && rx_take) || (!is_rx && tx_take)) begin
                seen = 1'b1;
                addr = int'(mem_addr);
                wdat = int'(mem_wdata);
                rdat = int'(tx_data);
                we   = mem_we;
            end
        end
    endtask

    task automatic quiet_window(input string req, input string what);
        bit any = 1'b0;
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            if (mem_req || rx_take || tx_take) any = 1'b1;
        end
        chk(!any, req, what, int'(any), 0);
    endtask

    task automatic rx_run(input int base, input int cnt, input int lat, input int seed);
        bit seen, we; int a, wd, rd;
        mem_lat = lat;
        cfg_write(2'd0, base);
        cfg_write(2'd1, cnt);
        chk(end_rx == 1'b0, "R7", "rx end flag after arm", int'(end_rx), 0);
        for (int i = 0; i < cnt; i++) begin
            rx_data = pat(seed, i); rx_ready = 1'b1;
            wait_take(1'b1, seen, a, wd, rd, we);
            rx_ready = 1'b0;
            chk(seen, "R3", "rx take seen", int'(seen), 1);
            chk(we == 1'b1, "R3", "rx request is a write", int'(we), 1);
            chk(wd == int'(pat(seed, i)), "R3", "rx write data", wd, int'(pat(seed, i)));
            if (i == 0) chk(a == base, "R2", "rx pointer load", a, base);
            else        chk(a == base + i, "R5", "rx address step", a, base + i);
            @(negedge clk);
            chk(end_rx == (i == cnt - 1), "R6", "rx end flag", int'(end_rx), int'(i == cnt - 1));
        end
        rx_ready = 1'b1; rx_data = 8'hEE;
        quiet_window("R6", "rx request after count exhausted");
        rx_ready = 1'b0;
        for (int i = 0; i < cnt; i++)
            chk(mem[8'(base + i)] == pat(seed, i), "R3", "rx memory contents",
                int'(mem[8'(base + i)]), int'(pat(seed, i)));
    endtask

    task automatic tx_run(input int base, input int cnt, input int lat, input int seed);
        bit seen, we; int a, wd, rd;
        mem_lat = lat;
        for (int i = 0; i < cnt; i++) preload(base + i, pat(seed, i));
        cfg_write(2'd2, base);
        cfg_write(2'd3, cnt);
        chk(end_tx == 1'b0, "R7", "tx end flag after arm", int'(end_tx), 0);
        for (int i = 0; i < cnt; i++) begin
            tx_ready = 1'b1;
            wait_take(1'b0, seen, a, wd, rd, we);
            tx_ready = 1'b0;
            chk(seen, "R4", "tx take seen", int'(seen), 1);
            chk(we == 1'b0, "R4", "tx request is a read", int'(we), 0);
            chk(rd == int'(pat(seed, i)), "R4", "tx data", rd, int'(pat(seed, i)));
            if (i == 0) chk(a == base, "R2", "tx pointer load", a, base);
            else        chk(a == base + i, "R5", "tx address step", a, base + i);
            @(negedge clk);
            chk(end_tx == (i == cnt - 1), "R6", "tx end flag", int'(end_tx), int'(i == cnt - 1));
        end
        tx_ready = 1'b1;
        quiet_window("R6", "tx request after count exhausted");
        tx_ready = 1'b0;
    endtask

    initial begin
        bit seen, we, rx_first; int a, wd, rd;
        repeat (3) @(negedge clk);
        chk(!mem_req && !rx_take && !tx_take, "R1", "outputs in reset",
            int'({mem_req, rx_take, tx_take}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!end_rx && !end_tx && !mem_req, "R1", "outputs after reset",
            int'({end_rx, end_tx, mem_req}), 0);

        // sweeps over count and memory latency
        for (int c = 1; c <= 4; c++)
            for (int l = 0; l <= 2; l++) begin
                rx_run((c * 3 + l) * 8, c, l, c * 5 + l);
                tx_run(128 + (c * 3 + l) * 8, c, l, c * 7 + l + 1);
            end

        // R9: both ready in the same idle cycle
        mem_lat = 1;
        preload(8'h50, 8'h3C);
        cfg_write(2'd0, 16'h40); cfg_write(2'd1, 1);
        cfg_write(2'd2, 16'h50); cfg_write(2'd3, 1);
        @(negedge clk);
        rx_data = 8'hA5; rx_ready = 1'b1; tx_ready = 1'b1;
        @(negedge clk);
        chk(mem_req && mem_we, "R9", "first request is receive", int'({mem_req, mem_we}), 3);
        rx_first = 1'b0;
        for (int k = 0; k < 40; k++) begin
            if (rx_take && !rx_first) begin rx_first = 1'b1; rx_ready = 1'b0; end
            chk(!(tx_take && !rx_first), "R9", "tx served before rx", 1, 0);
            if (tx_take) begin
                chk(tx_data == 8'h3C, "R4", "tx data after contention", int'(tx_data), 'h3C);
                tx_ready = 1'b0;
            end
            @(negedge clk);
        end
        rx_ready = 1'b0; tx_ready = 1'b0;
        chk(end_rx && end_tx, "R9", "both channels finished", int'({end_rx, end_tx}), 3);
        chk(mem[8'h40] == 8'hA5, "R9", "rx data stored", int'(mem[8'h40]), 'hA5);

        // R8: nine-bit mode blocks transfers
        mem_lat = 0;
        nine_bit = 1'b1;
        cfg_write(2'd0, 16'h60); cfg_write(2'd1, 1);
        rx_data = 8'h77; rx_ready = 1'b1;
        quiet_window("R8", "request while nine_bit");
        nine_bit = 1'b0;
        wait_take(1'b1, seen, a, wd, rd, we);
        rx_ready = 1'b0;
        chk(seen && a == 16'h60, "R8", "transfer after nine_bit cleared", a, 'h60);

        // R7: zero count stops, non-zero resumes from current pointer
        cfg_write(2'd0, 16'h70); cfg_write(2'd1, 3);
        rx_data = 8'h11; rx_ready = 1'b1;
        wait_take(1'b1, seen, a, wd, rd, we);
        rx_ready = 1'b0;
        chk(seen && a == 16'h70, "R7", "first transfer before stop", a, 'h70);
        cfg_write(2'd1, 0);
        rx_data = 8'h22; rx_ready = 1'b1;
        quiet_window("R7", "request after zero count");
        chk(end_rx == 1'b0, "R7", "zero count keeps end flag", int'(end_rx), 0);
        cfg_write(2'd1, 1);
        wait_take(1'b1, seen, a, wd, rd, we);
        rx_ready = 1'b0;
        chk(seen && a == 16'h71, "R7", "resume at current pointer", a, 'h71);
        @(negedge clk);
        chk(end_rx == 1'b1, "R6", "end flag after resumed run", int'(end_rx), 1);
        cfg_write(2'd1, 2);
        chk(end_rx == 1'b0, "R7", "non-zero count clears end flag", int'(end_rx), 0);

        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule